// File: doc/BRIEF.md
# Multi-Cycle Instruction Control Sequencer

This block is the control state machine of a non-pipelined 16-bit processor. It walks the datapath through each instruction one clock at a time. It raises the load enables and select lines for the program counter, the memory address register (MAR), the memory data register (MDR), the instruction register and the register-file write port. It also drives the read and write strobes of an external SRAM. Every instruction starts with the same two-cycle fetch, followed by a decode cycle and an execute cycle. Instructions that touch memory then continue into extra states that run an SRAM bus cycle through the MAR and MDR.

A separate combinational decoder sits next to this block. It reads the instruction register and supplies a 3-bit instruction class, plus a branch-taken flag worked out from the condition codes. Mux settings that depend only on the opcode come from that decoder, not from here. This block only decides *when* things happen: which register latches, which SRAM strobe is active, and when the current instruction finishes. A one-cycle `done` strobe marks the last cycle of every instruction.

Top module: `mcseq_top`

## Requirements
- R1: A synchronous active-high reset puts the sequencer into the fetch-address state. On the clock after reset is sampled, the outputs show that state: `mar_en`=1 and `mar_sel`=0, with `pc_en`, `rf_we`, `sram_we`, `ir_en` and `done` all 0. This holds even if reset arrives in the middle of an instruction.
- R2: Every instruction opens with two fetch cycles. In the first, `mar_en`=1 and `mar_sel`=0, which selects the PC. In the second, `sram_oe`=1 and `ir_en`=1. Both cycles are the same whatever `iclass` and `br_taken` hold.
- R3: The third cycle of every instruction is a decode cycle with all strobes at 0. The fourth cycle is the execute cycle.
- R4: `pc_en` is 1 in exactly one cycle of each instruction, the execute cycle. The encoding of `pc_sel` is 0 for increment, 1 for add signed offset and 2 for load from register.
- R5: Class 0 (ALU) takes five cycles. The cycle after execute asserts `rf_we`=1 with `rf_src`=0 (ALU result) and `done`=1.
- R6: Class 1 (load) takes seven cycles. After execute come three cycles in order. First: `mar_en`=1 with `mar_sel`=1 (ALU address). Second: `sram_oe`=1 and `mdr_en`=1 with `mdr_sel`=0 (SRAM data). Third: `rf_we`=1 with `rf_src`=1 (memory data) and `done`=1.
- R7: Class 2 (store) takes seven cycles. After execute come three cycles in order. First: `mar_en`=1 with `mar_sel`=1. Second: `mdr_en`=1 with `mdr_sel`=1 (register data). Third: `sram_we`=1, `bus_drive`=1 and `done`=1. `rf_we` stays 0 throughout the store.
- R8: Class 3 (branch) takes four cycles. The execute cycle uses `pc_sel`=1 when `br_taken` is 1 and `pc_sel`=0 when it is 0, and asserts `done`. `br_taken` has no effect in any other cycle or class.
- R9: Class 4 (jump) and class 5 (jump-and-link) take four cycles, with `pc_sel`=2 in execute. For jump-and-link, the same execute cycle also asserts `rf_we`=1 with `rf_src`=2 (incremented PC), so the link is written at the same edge the PC changes.
- R10: `sram_oe` and `sram_we` are never 1 in the same cycle.
- R11: `done` is 1 only in the final cycle of an instruction, and the next cycle is a fetch-address cycle.
- R12: Codes 6 and 7 are unassigned. They behave as a no-operation: four cycles, `pc_sel`=0 in execute, and no register, MDR or SRAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iclass | input | 3 | Instruction class from the decoder (0 ALU, 1 load, 2 store, 3 branch, 4 jump, 5 jump-and-link) |
| br_taken | input | 1 | Branch condition met, read in execute |
| pc_en | output | 1 | Program counter load enable |
| pc_sel | output | 2 | PC next-value select |
| mar_en | output | 1 | MAR load enable |
| mar_sel | output | 1 | MAR source: 0 PC, 1 ALU |
| mdr_en | output | 1 | MDR load enable |
| mdr_sel | output | 1 | MDR source: 0 SRAM, 1 register |
| ir_en | output | 1 | Instruction register load enable |
| rf_we | output | 1 | Register-file write enable |
| rf_src | output | 2 | Write-back source: 0 ALU, 1 memory, 2 link |
| sram_oe | output | 1 | SRAM output enable (read) |
| sram_we | output | 1 | SRAM write enable |
| bus_drive | output | 1 | MDR drives the SRAM data bus |
| done | output | 1 | Final cycle of the current instruction |

## Verification
Every strobe decodes straight from the state register. A change of state caused by `iclass` during execute therefore shows at the ports one clock later. Likewise, a reset sampled at an edge shows fetch-address outputs right after that edge. `br_taken` acts in the same cycle it is presented, because it only shapes `pc_sel` in execute.

The bench drives its inputs on falling edges. It holds a per-instruction queue of expected strobe words, built from the cycle counts above, and pops and compares one word on every falling edge. Before decode it feeds a wrong class, and outside execute it drives the opposite branch flag, so that any early dependence on those inputs shows up as a mismatch.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;

    localparam int CLS_W   = 3;
    localparam int PCSEL_W = 2;
    localparam int RFSRC_W = 2;
    localparam int STATE_W = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU    = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_BRANCH = 3'd3,
        CLS_JUMP   = 3'd4,
        CLS_JAL    = 3'd5,
        CLS_RSV6   = 3'd6,
        CLS_RSV7   = 3'd7
    } iclass_e;

    typedef enum logic [STATE_W-1:0] {
        S_FADDR  = 4'd0,
        S_FREAD  = 4'd1,
        S_DEC    = 4'd2,
        S_EXEC   = 4'd3,
        S_WB     = 4'd4,
        S_LADDR  = 4'd5,
        S_LREAD  = 4'd6,
        S_LWB    = 4'd7,
        S_SADDR  = 4'd8,
        S_SDATA  = 4'd9,
        S_SWRITE = 4'd10
    } state_e;

    localparam logic [PCSEL_W-1:0] PC_INC  = 2'd0;
    localparam logic [PCSEL_W-1:0] PC_OFF  = 2'd1;
    localparam logic [PCSEL_W-1:0] PC_REG  = 2'd2;
    localparam logic               MAR_PC  = 1'b0;
    localparam logic               MAR_ALU = 1'b1;
    localparam logic               MDR_MEM = 1'b0;
    localparam logic               MDR_REG = 1'b1;
    localparam logic [RFSRC_W-1:0] RF_ALU  = 2'd0;
    localparam logic [RFSRC_W-1:0] RF_MEM  = 2'd1;
    localparam logic [RFSRC_W-1:0] RF_LINK = 2'd2;

    typedef struct packed {
        logic               pc_en;
        logic [PCSEL_W-1:0] pc_sel;
        logic               mar_en;
        logic               mar_sel;
        logic               mdr_en;
        logic               mdr_sel;
        logic               ir_en;
        logic               rf_we;
        logic [RFSRC_W-1:0] rf_src;
        logic               sram_oe;
        logic               sram_we;
        logic               bus_drive;
        logic               done;
    } strobe_t;

    function automatic logic [PCSEL_W-1:0] pc_choice(iclass_e c, logic taken);
        case (c)
            CLS_BRANCH:        return taken ? PC_OFF : PC_INC;
            CLS_JUMP, CLS_JAL: return PC_REG;
            default:           return PC_INC;
        endcase
    endfunction

    function automatic logic ends_in_exec(iclass_e c);
        return !(c == CLS_ALU || c == CLS_LOAD || c == CLS_STORE);
    endfunction

endpackage

// File: rtl/mcseq_state.sv
module mcseq_state
    import mcseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  iclass_e cls,
    output state_e  state
);

    state_e nxt;

    always_comb begin
        nxt = S_FADDR;
        case (state)
            S_FADDR: nxt = S_FREAD;
            S_FREAD: nxt = S_DEC;
            S_DEC:   nxt = S_EXEC;
            S_EXEC: begin
                case (cls)
                    CLS_ALU:   nxt = S_WB;
                    CLS_LOAD:  nxt = S_LADDR;
                    CLS_STORE: nxt = S_SADDR;
                    default:   nxt = S_FADDR;
                endcase
            end
            S_LADDR: nxt = S_LREAD;
            S_LREAD: nxt = S_LWB;
            S_SADDR: nxt = S_SDATA;
            S_SDATA: nxt = S_SWRITE;
            default: nxt = S_FADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_FADDR;
        else     state <= nxt;
    end

endmodule

// File: rtl/mcseq_strobes.sv
module mcseq_strobes
    import mcseq_pkg::*;
(
    input  state_e  state,
    input  iclass_e cls,
    input  logic    taken,
    output strobe_t stb
);

    always_comb begin
        stb = '0;
        case (state)
            S_FADDR: begin
                stb.mar_en  = 1'b1;
                stb.mar_sel = MAR_PC;
            end
            S_FREAD: begin
                stb.sram_oe = 1'b1;
                stb.ir_en   = 1'b1;
            end
            S_EXEC: begin
                stb.pc_en  = 1'b1;
                stb.pc_sel = pc_choice(cls, taken);
                if (cls == CLS_JAL) begin
                    stb.rf_we  = 1'b1;
                    stb.rf_src = RF_LINK;
                end
                stb.done = ends_in_exec(cls);
            end
            S_WB: begin
                stb.rf_we  = 1'b1;
                stb.rf_src = RF_ALU;
                stb.done   = 1'b1;
            end
            S_LADDR, S_SADDR: begin
                stb.mar_en  = 1'b1;
                stb.mar_sel = MAR_ALU;
            end
            S_LREAD: begin
                stb.sram_oe = 1'b1;
                stb.mdr_en  = 1'b1;
                stb.mdr_sel = MDR_MEM;
            end
            S_LWB: begin
                stb.rf_we  = 1'b1;
                stb.rf_src = RF_MEM;
                stb.done   = 1'b1;
            end
            S_SDATA: begin
                stb.mdr_en  = 1'b1;
                stb.mdr_sel = MDR_REG;
            end
            S_SWRITE: begin
                stb.sram_we   = 1'b1;
                stb.bus_drive = 1'b1;
                stb.done      = 1'b1;
            end
            default: stb = '0;
        endcase
    end

endmodule

// File: rtl/mcseq_top.sv
module mcseq_top
    import mcseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CLS_W-1:0]   iclass,
    input  logic               br_taken,
    output logic               pc_en,
    output logic [PCSEL_W-1:0] pc_sel,
    output logic               mar_en,
    output logic               mar_sel,
    output logic               mdr_en,
    output logic               mdr_sel,
    output logic               ir_en,
    output logic               rf_we,
    output logic [RFSRC_W-1:0] rf_src,
    output logic               sram_oe,
    output logic               sram_we,
    output logic               bus_drive,
    output logic               done
);

    iclass_e cls;
    state_e  state;
    strobe_t stb;

    assign cls = iclass_e'(iclass);

    mcseq_state u_state (
        .clk   (clk),
        .rst   (rst),
        .cls   (cls),
        .state (state)
    );

    mcseq_strobes u_strobes (
        .state (state),
        .cls   (cls),
        .taken (br_taken),
        .stb   (stb)
    );

    assign pc_en     = stb.pc_en;
    assign pc_sel    = stb.pc_sel;
    assign mar_en    = stb.mar_en;
    assign mar_sel   = stb.mar_sel;
    assign mdr_en    = stb.mdr_en;
    assign mdr_sel   = stb.mdr_sel;
    assign ir_en     = stb.ir_en;
    assign rf_we     = stb.rf_we;
    assign rf_src    = stb.rf_src;
    assign sram_oe   = stb.sram_oe;
    assign sram_we   = stb.sram_we;
    assign bus_drive = stb.bus_drive;
    assign done      = stb.done;

endmodule

// File: rtl/mcseq_chk.sv
module mcseq_chk
    import mcseq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               pc_en,
    input logic               mar_en,
    input logic               mar_sel,
    input logic               mdr_en,
    input logic               ir_en,
    input logic               rf_we,
    input logic [RFSRC_W-1:0] rf_src,
    input logic               sram_oe,
    input logic               sram_we,
    input logic               bus_drive,
    input logic               done
);

    logic [1:0] pc_cnt;

    always_ff @(posedge clk) begin
        if (rst || done)                pc_cnt <= 2'd0;
        else if (pc_en && pc_cnt != 2'd3) pc_cnt <= pc_cnt + 2'd1;
    end

    // R1
    reset_to_fetch_chk: assert property (@(posedge clk)
        rst |=> (mar_en && mar_sel == MAR_PC && !rf_we && !sram_we && !pc_en && !done));

    // R2
    fetch_read_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
        ir_en |-> (sram_oe && $past(mar_en && mar_sel == MAR_PC)));

    // R4
    one_pc_update_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((pc_cnt + {1'b0, pc_en}) == 2'd1));

    // R6
    load_wb_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_we && rf_src == RF_MEM) |-> $past(sram_oe && mdr_en));

    // R7
    store_write_after_mdr_chk: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> (bus_drive && $past(mdr_en)));

    // R10
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sram_oe && sram_we));

    // R11
    done_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (mar_en && mar_sel == MAR_PC && !pc_en && !done));

endmodule

bind mcseq_top mcseq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pc_en     (pc_en),
    .mar_en    (mar_en),
    .mar_sel   (mar_sel),
    .mdr_en    (mdr_en),
    .ir_en     (ir_en),
    .rf_we     (rf_we),
    .rf_src    (rf_src),
    .sram_oe   (sram_oe),
    .sram_we   (sram_we),
    .bus_drive (bus_drive),
    .done      (done)
);

// File: tb/mcseq_top_tb.sv
`timescale 1ns/1ps
module mcseq_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] iclass = 3'd7;
    logic       br_taken = 1'b0;
    logic       pc_en, mar_en, mar_sel, mdr_en, mdr_sel, ir_en, rf_we;
    logic       sram_oe, sram_we, bus_drive, done;
    logic [1:0] pc_sel, rf_src;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mcseq_top u_dut (
        .clk(clk), .rst(rst), .iclass(iclass), .br_taken(br_taken),
        .pc_en(pc_en), .pc_sel(pc_sel), .mar_en(mar_en), .mar_sel(mar_sel),
        .mdr_en(mdr_en), .mdr_sel(mdr_sel), .ir_en(ir_en), .rf_we(rf_we),
        .rf_src(rf_src), .sram_oe(sram_oe), .sram_we(sram_we),
        .bus_drive(bus_drive), .done(done)
    );

    // field order: pc_en pc_sel mar_en mar_sel mdr_en mdr_sel ir_en rf_we rf_src oe we bus done
    function automatic logic [14:0] w(bit pe, bit [1:0] ps, bit me, bit ms, bit de, bit ds,
                                      bit ie, bit rw, bit [1:0] rs, bit oe, bit we, bit bd, bit dn);
        return {pe, ps, me, ms, de, ds, ie, rw, rs, oe, we, bd, dn};
    endfunction

    function automatic logic [14:0] actual();
        return {pc_en, pc_sel, mar_en, mar_sel, mdr_en, mdr_sel, ir_en, rf_we,
                rf_src, sram_oe, sram_we, bus_drive, done};
    endfunction

    task automatic check(input logic [14:0] exp, input string tag);
        total++;
        if (actual() !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, actual(), exp);
        end
        total++;
        if (sram_oe === 1'b1 && sram_we === 1'b1) begin
            bad++;
            $display("FAIL R10: actual oe=1 we=1 expected not both");
        end
    endtask

    // Build the expected cycle list of one instruction from the requirements.
    task automatic build(input int cls, input bit tk,
                         ref logic [14:0] eq[$], ref string tq[$]);
        eq.push_back(w(0,0,1,0,0,0,0,0,0,0,0,0,0)); tq.push_back("R2 fetch-addr");
        eq.push_back(w(0,0,0,0,0,0,1,0,0,1,0,0,0)); tq.push_back("R2 fetch-read");
        eq.push_back(w(0,0,0,0,0,0,0,0,0,0,0,0,0)); tq.push_back("R3 decode");
        case (cls)
            0: begin
                eq.push_back(w(1,0,0,0,0,0,0,0,0,0,0,0,0)); tq.push_back("R4 alu exec");
                eq.push_back(w(0,0,0,0,0,0,0,1,0,0,0,0,1)); tq.push_back("R5 alu wb");
            end
            1: begin
                eq.push_back(w(1,0,0,0,0,0,0,0,0,0,0,0,0)); tq.push_back("R4 load exec");
                eq.push_back(w(0,0,1,1,0,0,0,0,0,0,0,0,0)); tq.push_back("R6 load addr");
                eq.push_back(w(0,0,0,0,1,0,0,0,0,1,0,0,0)); tq.push_back("R6 load read");
                eq.push_back(w(0,0,0,0,0,0,0,1,1,0,0,0,1)); tq.push_back("R6 load wb");
            end
            2: begin
                eq.push_back(w(1,0,0,0,0,0,0,0,0,0,0,0,0)); tq.push_back("R4 store exec");
                eq.push_back(w(0,0,1,1,0,0,0,0,0,0,0,0,0)); tq.push_back("R7 store addr");
                eq.push_back(w(0,0,0,0,1,1,0,0,0,0,0,0,0)); tq.push_back("R7 store data");
                eq.push_back(w(0,0,0,0,0,0,0,0,0,0,1,1,1)); tq.push_back("R7 store write");
            end
            3: begin
                eq.push_back(w(1, tk ? 2'd1 : 2'd0, 0,0,0,0,0,0,0,0,0,0,1));
                tq.push_back("R8 branch exec");
            end
            4: begin
                eq.push_back(w(1,2,0,0,0,0,0,0,0,0,0,0,1)); tq.push_back("R9 jump exec");
            end
            5: begin
                eq.push_back(w(1,2,0,0,0,0,0,1,2,0,0,0,1)); tq.push_back("R9 jal exec");
            end
            default: begin
                eq.push_back(w(1,0,0,0,0,0,0,0,0,0,0,0,1)); tq.push_back("R12 unassigned exec");
            end
        endcase
    endtask

    // Entered at a falling edge while the fetch-address cycle is showing.
    task automatic run_instr(input int cls, input bit tk, input int rst_at);
        logic [14:0] eq[$];
        string tq[$];
        int n;
        build(cls, tk, eq, tq);
        n = eq.size();
        for (int i = 0; i < n; i++) begin
            check(eq.pop_front(), tq.pop_front());
            // wrong class during fetch (R2); branch flag valid only in execute (R8)
            iclass   = (i >= 1) ? 3'(cls) : 3'(cls ^ 3);
            br_taken = (i == 2) ? tk : ~tk;
            if (i == rst_at) begin
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                check(w(0,0,1,0,0,0,0,0,0,0,0,0,0), "R1 mid-instruction reset");
                return;
            end
            @(negedge clk);
        end
        // R11: cycle after done must be fetch-address
        check(w(0,0,1,0,0,0,0,0,0,0,0,0,0), "R11 back to fetch");
    endtask

    initial begin
        #(5.0 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(w(0,0,1,0,0,0,0,0,0,0,0,0,0), "R1 reset state");
        rst = 1'b0;
        run_instr(0, 1, -1);   // R5, flag ignored
        run_instr(1, 0, -1);   // R6
        run_instr(2, 1, -1);   // R7
        run_instr(3, 1, -1);   // R8 taken
        run_instr(3, 0, -1);   // R8 not taken
        run_instr(4, 1, -1);   // R9 jump
        run_instr(5, 0, -1);   // R9 link
        run_instr(6, 1, -1);   // R12
        run_instr(7, 0, -1);   // R12
        run_instr(1, 0, 5);    // R1 reset during load read
        run_instr(2, 0, 4);    // R1 reset during store address
        run_instr(0, 0, -1);
        for (int k = 0; k < 40; k++) run_instr(k % 8, k[0], -1);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule